// File: doc/BRIEF.md
# Sprite Memory Block Copier

This block fills the sprite attribute area with 160 bytes taken from any 256-byte page of the system map. The CPU starts a copy by writing a page number to a control register. The same register returns the last written page when the CPU reads it. The copier waits one machine cycle after the write. It then moves one byte per machine cycle. The source address runs from the page base upward, and the destination runs from 0xFE00 upward.

While a copy is running, the block guards the CPU side of the system. Only accesses inside the top page (0xFF00 to 0xFFFF) are passed on to the rest of the system. Any other access is held back: reads return 0xFF and writes are dropped. All sequencing advances on a one-cycle machine-cycle strobe, so the system clock may run faster than the copy rate. A new write to the control register during a copy starts the whole copy again from the newly written page.

Top module: `sprite_dma`

## Requirements
- R1: After reset, a read of the control register (address 0xFF46) returns 0xFF, `busy` is low and no sprite-memory write occurs.
- R2: A CPU write to 0xFF46 latches the byte. A CPU read of 0xFF46 returns that byte at any time, including during a copy. The register is never forwarded to the system bus.
- R3: After the clock edge that accepts the register write, the first clock edge with `mcycleEn` high only ends the start delay and raises `busy`, without moving a byte. The first byte moves at the next strobed edge.
- R4: A copy issues exactly 160 sprite writes. Write i, for i from 0 to 159, has source address page*0x100+i, destination address 0xFE00+i, and the data read from that source address in the same cycle.
- R5: `busy` is high in the cycle in which the 160th byte is written and low in the cycle after. Access to the full map is then restored.
- R6: While `busy` is high, a CPU access with address bits [15:8] not equal to 0xFF is blocked. `cpuGrant` is low, `fwdRdEn` and `fwdWrEn` stay low, and a read returns 0xFF.
- R7: While `busy` is high, CPU reads and writes in 0xFF00 to 0xFFFF (other than 0xFF46) are forwarded. `cpuGrant` is high, and read data comes from `fwdRdData`.
- R8: A register write during a copy restarts it. No byte moves in the write cycle, `busy` stays high, one strobe of delay passes, and the copy then begins at the new page with destination 0xFE00 and byte index 0.
- R9: Sprite writes and source reads happen only in cycles where `mcycleEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcycleEn | input | 1 | One-cycle machine-cycle strobe |
| cpuAddr | input | 16 | CPU address |
| cpuRdEn | input | 1 | CPU read request |
| cpuWrEn | input | 1 | CPU write request |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data (register, forwarded, or 0xFF when blocked) |
| cpuGrant | output | 1 | CPU address is currently reachable |
| fwdAddr | output | 16 | Forwarded CPU address to the system |
| fwdRdEn | output | 1 | Forwarded read enable |
| fwdWrEn | output | 1 | Forwarded write enable |
| fwdWrData | output | 8 | Forwarded write data |
| fwdRdData | input | 8 | Read data for forwarded reads |
| srcAddr | output | 16 | Copy source address |
| srcRdEn | output | 1 | Copy source read strobe |
| srcRdData | input | 8 | Source data, valid in the same cycle |
| oamWrEn | output | 1 | Sprite memory write enable |
| oamAddr | output | 16 | Sprite memory write address |
| oamWrData | output | 8 | Sprite memory write data |
| busy | output | 1 | Copy in progress and CPU lockout active |

## Verification
The bench targets the start delay. A design that moved a byte on the first strobe after the write would shift every address by one, and the scoreboard would see a byte it did not expect. It also aims a restart at the middle of a copy. A design that kept the old counter or old page, or that moved a byte in the restart cycle itself, would produce a write that does not match the new page's queue. Around the lockout, it reads low memory and the top page during a copy and again right after the last byte. A design with a late or early `busy`, or an open or closed window in the wrong place, returns the wrong data or forwards an access it should drop.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_RELOAD = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // latch new page, clear byte index
    logic step;  // move one byte, advance index
  } dmaCmd_t;

endpackage

// File: rtl/sprite_dma_gate.sv
module sprite_dma_gate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF46,
  parameter logic [7:0] OPEN_PAGE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRdEn,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              busy,
  input  logic [DATA_W-1:0] regValue,
  input  logic [DATA_W-1:0] fwdRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuGrant,
  output logic              regWrite,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              fwdRdEn,
  output logic              fwdWrEn,
  output logic [DATA_W-1:0] fwdWrData
);
  localparam logic [DATA_W-1:0] BLOCKED_DATA = {DATA_W{1'b1}};

  logic isReg;
  logic inOpen;

  always_comb begin
    isReg     = (cpuAddr == REG_ADDR);
    inOpen    = (cpuAddr[ADDR_W-1 -: 8] == OPEN_PAGE);
    cpuGrant  = !busy || inOpen;
    regWrite  = cpuWrEn && isReg;
    fwdAddr   = cpuAddr;
    fwdWrData = cpuWrData;
    fwdRdEn   = cpuRdEn && cpuGrant && !isReg;
    fwdWrEn   = cpuWrEn && cpuGrant && !isReg;
    if (isReg)         cpuRdData = regValue;
    else if (cpuGrant) cpuRdData = fwdRdData;
    else               cpuRdData = BLOCKED_DATA;
  end

  // R6: low memory is unreachable while locked
  assert_block_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cpuAddr[ADDR_W-1 -: 8] != OPEN_PAGE)) |-> (!fwdRdEn && !fwdWrEn))
    else $error("low access forwarded during copy");

  // R7: top page stays reachable while locked
  assert_open_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpuRdEn && (cpuAddr[ADDR_W-1 -: 8] == OPEN_PAGE) && (cpuAddr != REG_ADDR))
      |-> fwdRdEn)
    else $error("top page read not forwarded");

endmodule

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_dma_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mcycleEn,
  input  logic    regWrite,
  input  logic    lastByte,
  output dmaCmd_t cmd,
  output logic    busy
);
  seqState_t state, stateNext;

  always_comb begin
    cmd.load  = regWrite;
    cmd.step  = (state == ST_ACTIVE) && mcycleEn && !regWrite;
    busy      = (state == ST_ACTIVE) || (state == ST_RELOAD);
    stateNext = state;
    if (regWrite) begin
      stateNext = busy ? ST_RELOAD : ST_DELAY;
    end else begin
      unique case (state)
        ST_IDLE:   stateNext = ST_IDLE;
        ST_DELAY:  if (mcycleEn) stateNext = ST_ACTIVE;
        ST_RELOAD: if (mcycleEn) stateNext = ST_ACTIVE;
        ST_ACTIVE: if (cmd.step && lastByte) stateNext = ST_IDLE;
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // R3: lockout begins only on a strobed edge
  assert_busy_rise_strobed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mcycleEn))
    else $error("busy rose without strobe");

  // R9: no byte movement off-strobe
  assert_step_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.step |-> mcycleEn)
    else $error("step without strobe");

  // R8: a restart never drops the lockout
  assert_restart_keeps_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && regWrite) |=> busy)
    else $error("restart released lockout");

endmodule

// File: rtl/sprite_dma_path.sv
module sprite_dma_path
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_LEN = 160,
  parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00,
  parameter logic [DATA_W-1:0] RESET_PAGE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dmaCmd_t           cmd,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] srcRdData,
  output logic [DATA_W-1:0] regValue,
  output logic              lastByte,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              srcRdEn,
  output logic              oamWrEn,
  output logic [ADDR_W-1:0] oamAddr,
  output logic [DATA_W-1:0] oamWrData
);
  localparam int CNT_W = $clog2(XFER_LEN);
  localparam int LOW_W = ADDR_W - DATA_W;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(XFER_LEN - 1);

  logic [DATA_W-1:0] pageReg;
  logic [CNT_W-1:0]  byteIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pageReg <= RESET_PAGE;
      byteIdx <= '0;
    end else if (cmd.load) begin
      pageReg <= regWrData;
      byteIdx <= '0;
    end else if (cmd.step) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_comb begin
    regValue  = pageReg;
    lastByte  = (byteIdx == LAST_IDX);
    srcAddr   = {pageReg, {LOW_W{1'b0}}} + ADDR_W'(byteIdx);
    oamAddr   = DEST_BASE + ADDR_W'(byteIdx);
    srcRdEn   = cmd.step;
    oamWrEn   = cmd.step;
    oamWrData = srcRdData;
  end

  // R4: destination stays inside the sprite window
  assert_dest_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oamWrEn |-> ((oamAddr >= DEST_BASE) && (oamAddr < DEST_BASE + ADDR_W'(XFER_LEN))))
    else $error("destination outside window");

  // R4: source and destination offsets move together
  assert_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oamWrEn |-> ((oamAddr - DEST_BASE) == ADDR_W'(srcAddr[LOW_W-1:0])))
    else $error("source and destination out of step");

  // R8: a load always restarts from index zero
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> (oamAddr == DEST_BASE))
    else $error("restart did not rewind destination");

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_LEN = 160,
  parameter logic [15:0] REG_ADDR = 16'hFF46,
  parameter logic [15:0] DEST_BASE = 16'hFE00,
  parameter logic [7:0] OPEN_PAGE = 8'hFF,
  parameter logic [7:0] RESET_PAGE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mcycleEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRdEn,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuGrant,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              fwdRdEn,
  output logic              fwdWrEn,
  output logic [DATA_W-1:0] fwdWrData,
  input  logic [DATA_W-1:0] fwdRdData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              srcRdEn,
  input  logic [DATA_W-1:0] srcRdData,
  output logic              oamWrEn,
  output logic [ADDR_W-1:0] oamAddr,
  output logic [DATA_W-1:0] oamWrData,
  output logic              busy
);
  dmaCmd_t           cmd;
  logic              regWrite;
  logic              lastByte;
  logic [DATA_W-1:0] regValue;

  sprite_dma_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_ADDR(ADDR_W'(REG_ADDR)), .OPEN_PAGE(OPEN_PAGE)
  ) u_gate (
    .clk(clk), .rst_n(rst_n),
    .cpuAddr(cpuAddr), .cpuRdEn(cpuRdEn), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .busy(busy), .regValue(regValue), .fwdRdData(fwdRdData),
    .cpuRdData(cpuRdData), .cpuGrant(cpuGrant), .regWrite(regWrite),
    .fwdAddr(fwdAddr), .fwdRdEn(fwdRdEn), .fwdWrEn(fwdWrEn), .fwdWrData(fwdWrData)
  );

  sprite_dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mcycleEn(mcycleEn),
    .regWrite(regWrite), .lastByte(lastByte),
    .cmd(cmd), .busy(busy)
  );

  sprite_dma_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN),
    .DEST_BASE(ADDR_W'(DEST_BASE)), .RESET_PAGE(DATA_W'(RESET_PAGE))
  ) u_path (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .regWrData(cpuWrData), .srcRdData(srcRdData),
    .regValue(regValue), .lastByte(lastByte),
    .srcAddr(srcAddr), .srcRdEn(srcRdEn),
    .oamWrEn(oamWrEn), .oamAddr(oamAddr), .oamWrData(oamWrData)
  );

endmodule

// File: tb/sprite_dma_tb.sv
module sprite_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 160;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mcycleEn = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic        cpuRdEn = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [7:0]  cpuWrData = 8'h00;
  logic [7:0]  cpuRdData;
  logic        cpuGrant;
  logic [15:0] fwdAddr;
  logic        fwdRdEn, fwdWrEn;
  logic [7:0]  fwdWrData, fwdRdData;
  logic [15:0] srcAddr;
  logic        srcRdEn;
  logic [7:0]  srcRdData;
  logic        oamWrEn;
  logic [15:0] oamAddr;
  logic [7:0]  oamWrData;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int bytesSeen = 0;
  bit lastPopped = 1'b0;
  logic [23:0] expQ[$];

  function automatic logic [7:0] srcFn(input logic [15:0] a);
    logic [7:0] hi;
    hi = a[15:8] * 8'd7;
    return hi ^ (a[7:0] + 8'd3);
  endfunction

  assign srcRdData = srcFn(srcAddr);
  assign fwdRdData = fwdAddr[7:0] ^ 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) mcycleEn <= 1'b0;
    else        mcycleEn <= ~mcycleEn;
  end

  sprite_dma u_dut (
    .clk(clk), .rst_n(rst_n), .mcycleEn(mcycleEn),
    .cpuAddr(cpuAddr), .cpuRdEn(cpuRdEn), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .cpuGrant(cpuGrant),
    .fwdAddr(fwdAddr), .fwdRdEn(fwdRdEn), .fwdWrEn(fwdWrEn), .fwdWrData(fwdWrData),
    .fwdRdData(fwdRdData),
    .srcAddr(srcAddr), .srcRdEn(srcRdEn), .srcRdData(srcRdData),
    .oamWrEn(oamWrEn), .oamAddr(oamAddr), .oamWrData(oamWrData),
    .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: queue the expected copy of one page
  task automatic pushPage(input logic [7:0] page);
    for (int i = 0; i < LEN; i++) begin
      logic [15:0] s;
      s = {page, 8'h00} + 16'(i);
      expQ.push_back({16'hFE00 + 16'(i), srcFn(s)});
    end
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d, input bit restart);
    @(posedge clk); #1;
    if (restart) begin
      expQ.delete();
      pushPage(d);
    end
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(posedge clk); #1;
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [15:0] a, output logic [7:0] d, output logic g, output logic f);
    @(posedge clk); #1;
    cpuAddr = a; cpuRdEn = 1'b1;
    @(negedge clk);
    d = cpuRdData; g = cpuGrant; f = fwdRdEn;
    @(posedge clk); #1;
    cpuRdEn = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (busy || expQ.size() != 0);
  endtask

  // Monitor: compare every sprite write with the queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if (lastPopped) begin
        check(busy == 1'b0, "R5 busy after last byte", busy, 0);
        lastPopped = 1'b0;
      end
      if (oamWrEn) begin
        logic [23:0] e;
        check(mcycleEn == 1'b1, "R9 write only on strobe", mcycleEn, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected sprite write", oamAddr, 0);
        end else begin
          e = expQ.pop_front();
          check({oamAddr, oamWrData} == e, "R4 sprite write addr/data",
                {oamAddr, oamWrData}, e);
          bytesSeen++;
          if (expQ.size() == 0) begin
            check(busy == 1'b1, "R5 busy during last byte", busy, 1);
            lastPopped = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic g, f;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cpuRead(16'hFF46, d, g, f);
    check(d == 8'hFF, "R1 register reset value", d, 8'hFF);
    check(busy == 1'b0, "R1 idle after reset", busy, 0);
    check(bytesSeen == 0, "R1 no writes after reset", bytesSeen, 0);

    // Full copy of page 0x12 with R3 delay checks
    pushPage(8'h12);
    cpuWrite(16'hFF46, 8'h12, 1'b0);
    do begin
      @(negedge clk);
      check(busy == 1'b0, "R3 idle during start delay", busy, 0);
    end while (!mcycleEn);
    @(posedge clk); #1;
    check(busy == 1'b1, "R3 busy after first strobe", busy, 1);
    check(expQ.size() == LEN, "R3 no byte moved by delay strobe", expQ.size(), LEN);

    cpuRead(16'h1234, d, g, f);
    check(d == 8'hFF, "R6 blocked read data", d, 8'hFF);
    check(g == 1'b0, "R6 grant low", g, 0);
    check(f == 1'b0, "R6 read not forwarded", f, 0);
    @(posedge clk); #1;
    cpuAddr = 16'hC000; cpuWrData = 8'h55; cpuWrEn = 1'b1;
    @(negedge clk);
    check(fwdWrEn == 1'b0, "R6 blocked write dropped", fwdWrEn, 0);
    @(posedge clk); #1 cpuWrEn = 1'b0;
    check(expQ.size() < LEN, "R6 copy continues", expQ.size(), LEN - 1);

    cpuRead(16'hFF80, d, g, f);
    check(d == (8'h80 ^ 8'hA5), "R7 top page read data", d, 8'h80 ^ 8'hA5);
    check(g == 1'b1 && f == 1'b1, "R7 top page forwarded", {g, f}, 2'b11);
    cpuRead(16'hFF46, d, g, f);
    check(d == 8'h12, "R2 readback during copy", d, 8'h12);
    check(f == 1'b0, "R2 register not forwarded", f, 0);

    waitDone();
    check(bytesSeen == LEN, "R4 byte count", bytesSeen, LEN);
    cpuRead(16'h1234, d, g, f);
    check(d == (8'h34 ^ 8'hA5) && g == 1'b1, "R5 access restored", d, 8'h34 ^ 8'hA5);

    // R8 restart in the middle of a copy
    bytesSeen = 0;
    pushPage(8'h40);
    cpuWrite(16'hFF46, 8'h40, 1'b0);
    do @(negedge clk); while (expQ.size() > 110);
    cpuWrite(16'hFF46, 8'hC3, 1'b1);
    check(busy == 1'b1, "R8 busy held across restart", busy, 1);
    check(expQ.size() == LEN, "R8 no byte in restart cycle", expQ.size(), LEN);
    waitDone();
    cpuRead(16'hFF46, d, g, f);
    check(d == 8'hC3, "R8 register holds new page", d, 8'hC3);

    // Page 0x00 copy, R2 readback after completion
    pushPage(8'h00);
    cpuWrite(16'hFF46, 8'h00, 1'b0);
    waitDone();
    cpuRead(16'hFF46, d, g, f);
    check(d == 8'h00, "R2 readback after copy", d, 8'h00);
    check(busy == 1'b0, "R5 idle at end", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule